// File: doc/BRIEF.md
# Streaming Running-Median Filter

This block filters a one-dimensional stream of unsigned samples. It keeps the last `N` accepted samples and, after each new one, gives their median. `N` is an odd parameter of at least 3, and `W` is the sample width. The block does not sort the whole window again on every sample. It holds the window as an array of cells in ascending order, and each cell carries a value and the number of samples accepted since that value came in.

When a sample is accepted, the block does two things in the same clock edge. It removes the cell that holds the oldest value, and it places the new sample at its ordered position. Each cell compares the new sample with its own value, and these comparisons decide whether the cell keeps its contents, takes its left neighbour's, takes its right neighbour's, or loads the new sample. The median is the middle cell of the array. It is marked valid for one cycle after each accepted sample, once the window holds `N` real samples.

A typical use is to remove impulse noise from a sensor or scan-line stream, where a single outlier must not move the output.

Top module: `running_median`

## Requirements
- R1: While `rst` is high at a rising clock edge, the window is cleared to zeros. In the following cycle `med_valid` is 0 and `med_value` is 0.
- R2: `med_valid` is high in exactly the cycles that follow an accepted sample (`in_valid` high at the previous edge), and only once at least `N` samples have been accepted since reset.
- R3: When `med_valid` is high, `med_value` equals element `(N-1)/2` of the last `N` accepted samples. The samples are compared as unsigned numbers and sorted in ascending order, so the element counts from the smallest.
- R4: A cycle with `in_valid` low changes nothing in the window. In the next cycle `med_valid` is 0 and `med_value` is unchanged, and the median after the next accepted sample still uses the samples from before the gap.
- R5: Equal samples count as separate window entries. A new sample equal to existing values is placed after them, so the cell array stays in non-decreasing order at every cycle.
- R6: Each accepted sample evicts exactly the oldest sample in the window, whatever its value and position. At any cycle exactly one cell is marked oldest.
- R7: A reset in the middle of a stream discards the window. `med_valid` then stays low until `N` new samples have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the block acts on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The sample on `in_sample` is accepted at this edge |
| in_sample | input | W | Unsigned input sample |
| med_valid | output | 1 | One-cycle strobe: `med_value` is the median for the newest sample |
| med_value | output | W | Median of the current window |

## Verification
Insertion and eviction always happen in the same clock edge. The hard cases are the ones where the cell being freed and the insertion point are the same cell, are neighbours, or lie at opposite ends of the array. The bench provokes these cases with rising and falling ramps, where the oldest value sits at one extreme and the new value lands at the other, and with constant or heavily repeated values, where the new value ties with the value being evicted. Each median is judged against a model that keeps the last samples, sorts them and picks the middle one. The same stream is run through windows of 3, 5 and 7 at once.

// File: rtl/rmed_pkg.sv
package rmed_pkg;

   // Source a cell loads its next contents from on an accepted sample.
   typedef enum logic [1:0] {
      SRC_OWN   = 2'd0,
      SRC_LEFT  = 2'd1,
      SRC_RIGHT = 2'd2,
      SRC_NEW   = 2'd3
   } rmed_src_e;

   function automatic int rmed_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rmed_locate.sv
// Turns the per-cell compare results and the oldest-cell marker into a
// per-cell source select. The array is ascending, so le[] is a thermometer.
module rmed_locate
   import rmed_pkg::*;
#(
   parameter int N = 5
) (
   input  logic [N-1:0]            le,
   input  logic [N-1:0]            old,
   output rmed_src_e [N-1:0]       sel
);

   logic [N:0]   le_ext;
   logic         old_is_le;
   logic [N:0]   bp_ext;   // bp_ext[i+1]: cell i lies below the insertion point
   logic [N:0]   be_ext;   // be_ext[i+1]: cell i lies below the evicted cell
   logic [N-1:0] older_above;

   assign le_ext    = {1'b0, le};
   assign old_is_le = |(old & le);

   always_comb begin
      older_above[N-1] = 1'b0;
      for (int i = N-2; i >= 0; i--) begin
         older_above[i] = older_above[i+1] | old[i+1];
      end
   end

   always_comb begin
      bp_ext[0] = 1'b1;
      be_ext[0] = 1'b1;
      for (int i = 0; i < N; i++) begin
         bp_ext[i+1] = old_is_le ? le_ext[i+1] : le_ext[i];
         be_ext[i+1] = older_above[i];
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         if (bp_ext[i+1]) begin
            sel[i] = be_ext[i+1] ? SRC_OWN : SRC_RIGHT;
         end else if (bp_ext[i]) begin
            sel[i] = SRC_NEW;
         end else begin
            sel[i] = be_ext[i] ? SRC_LEFT : SRC_OWN;
         end
      end
   end

endmodule

// File: rtl/rmed_cell.sv
// One window cell: value, age, compare with the new sample, next-state mux.
module rmed_cell
   import rmed_pkg::*;
#(
   parameter int N   = 5,
   parameter int W   = 8,
   parameter int AW  = 3,
   parameter int IDX = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step,
   input  rmed_src_e     sel,
   input  logic [W-1:0]  x,
   input  logic [W-1:0]  left_v,
   input  logic [AW-1:0] left_a,
   input  logic [W-1:0]  right_v,
   input  logic [AW-1:0] right_a,
   output logic [W-1:0]  v,
   output logic [AW-1:0] a,
   output logic          le,
   output logic          old
);

   localparam logic [AW-1:0] AGE_LAST  = AW'(N - 1);
   localparam logic [AW-1:0] AGE_RESET = AW'(N - 1 - IDX);

   logic [W-1:0]  nv;
   logic [AW-1:0] na;

   assign le  = (v <= x);
   assign old = (a == AGE_LAST);

   always_comb begin
      unique case (sel)
         SRC_OWN:   begin nv = v;       na = a + AW'(1);       end
         SRC_LEFT:  begin nv = left_v;  na = left_a + AW'(1);  end
         SRC_RIGHT: begin nv = right_v; na = right_a + AW'(1); end
         default:   begin nv = x;       na = '0;               end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v <= '0;
         a <= AGE_RESET;
      end else if (step) begin
         v <= nv;
         a <= na;
      end
   end

endmodule

// File: rtl/running_median.sv
module running_median
   import rmed_pkg::*;
#(
   parameter int N = 5,
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [W-1:0] in_sample,
   output logic         med_valid,
   output logic [W-1:0] med_value
);

   localparam int AW  = rmed_bits(N);
   localparam int FW  = rmed_bits(N + 1);
   localparam int MID = (N - 1) / 2;
   localparam logic [FW-1:0] FILL_FULL = FW'(N);
   localparam logic [FW-1:0] FILL_LAST = FW'(N - 1);

   if ((N % 2) == 0 || N < 3) begin : g_bad_window
      $error("running_median: window N must be odd and at least 3");
   end
   if (W < 1) begin : g_bad_width
      $error("running_median: sample width W must be positive");
   end

   logic [N-1:0][W-1:0]  cell_v;
   logic [N-1:0][AW-1:0] cell_a;
   logic [N-1:0]         le_flag;
   logic [N-1:0]         old_flag;
   rmed_src_e [N-1:0]    sel;
   logic [FW-1:0]        fill;

   rmed_locate #(.N(N)) u_locate (
      .le  (le_flag),
      .old (old_flag),
      .sel (sel)
   );

   for (genvar i = 0; i < N; i++) begin : g_cell
      logic [W-1:0]  lv, rv;
      logic [AW-1:0] la, ra;

      if (i == 0) begin : g_lo_edge
         assign lv = '0;
         assign la = '0;
      end else begin : g_lo_link
         assign lv = cell_v[i-1];
         assign la = cell_a[i-1];
      end

      if (i == N - 1) begin : g_hi_edge
         assign rv = '0;
         assign ra = '0;
      end else begin : g_hi_link
         assign rv = cell_v[i+1];
         assign ra = cell_a[i+1];
      end

      rmed_cell #(.N(N), .W(W), .AW(AW), .IDX(i)) u_cell (
         .clk     (clk),
         .rst     (rst),
         .step    (in_valid),
         .sel     (sel[i]),
         .x       (in_sample),
         .left_v  (lv),
         .left_a  (la),
         .right_v (rv),
         .right_a (ra),
         .v       (cell_v[i]),
         .a       (cell_a[i]),
         .le      (le_flag[i]),
         .old     (old_flag[i])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         fill      <= '0;
         med_valid <= 1'b0;
      end else begin
         med_valid <= in_valid && (fill >= FILL_LAST);
         if (in_valid && fill != FILL_FULL) begin
            fill <= fill + FW'(1);
         end
      end
   end

   assign med_value = cell_v[MID];

endmodule

// File: rtl/rmed_check.sv
module rmed_check #(
   parameter int N = 5,
   parameter int W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic                med_valid,
   input logic [W-1:0]        med_value,
   input logic [N-1:0][W-1:0] cell_v,
   input logic [N-1:0]        old
);

   logic [31:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q <= '0;
      end else if (in_valid && seen_q < 32'(N)) begin
         seen_q <= seen_q + 32'd1;
      end
   end

   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (!med_valid && med_value == '0));

   a_r2_strobe_after_accept: assert property (@(posedge clk) disable iff (rst)
      med_valid |-> $past(in_valid));

   a_r2_not_before_full: assert property (@(posedge clk) disable iff (rst)
      med_valid |-> (seen_q >= 32'(N)));

   a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(med_value) && !med_valid));

   a_r6_single_oldest: assert property (@(posedge clk) disable iff (rst)
      $countones(old) == 1);

   for (genvar i = 0; i < N - 1; i++) begin : g_order
      a_r5_ascending: assert property (@(posedge clk) disable iff (rst)
         cell_v[i] <= cell_v[i+1]);
   end

endmodule

bind running_median rmed_check #(.N(N), .W(W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .med_valid (med_valid),
   .med_value (med_value),
   .cell_v    (cell_v),
   .old       (old_flag)
);

// File: tb/sim_running_median.sv
`timescale 1ns/1ps
module sim_running_median;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       vld = 1'b0;
   logic [7:0] din = '0;
   logic       v3, v5, v7;
   logic [7:0] m3, m5, m7;

   int checks = 0;
   int errors = 0;
   int sent   = 0;
   logic [7:0] hist [7];
   logic [31:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;

   running_median #(.N(5), .W(8)) u0 (
      .clk(clk), .rst(rst), .in_valid(vld), .in_sample(din),
      .med_valid(v5), .med_value(m5));
   running_median #(.N(3), .W(8)) u1 (
      .clk(clk), .rst(rst), .in_valid(vld), .in_sample(din),
      .med_valid(v3), .med_value(m3));
   running_median #(.N(7), .W(8)) u2 (
      .clk(clk), .rst(rst), .in_valid(vld), .in_sample(din),
      .med_valid(v7), .med_value(m7));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_median(input int n);
      logic [7:0] s [7];
      for (int k = 0; k < n; k++) s[k] = hist[k];
      for (int k = 1; k < n; k++) begin
         for (int j = k; j > 0; j--) begin
            if (s[j-1] > s[j]) begin
               logic [7:0] t = s[j];
               s[j] = s[j-1];
               s[j-1] = t;
            end
         end
      end
      return s[(n-1)/2];
   endfunction

   task automatic verify(input int n, input logic v, input logic [7:0] m, input string tag);
      check($sformatf("%s valid N=%0d", tag, n), int'(v), int'(sent >= n));
      if (sent >= n) check($sformatf("%s median N=%0d", tag, n), int'(m), int'(model_median(n)));
   endtask

   // Drive one accepted sample at a falling edge, check at the next one.
   task automatic push(input logic [7:0] x, input string tag);
      vld = 1'b1;
      din = x;
      for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      sent++;
      @(negedge clk);
      vld = 1'b0;
      verify(3, v3, m3, tag);
      verify(5, v5, m5, tag);
      verify(7, v7, m7, tag);
   endtask

   task automatic idle(input string tag);
      logic [7:0] p3 = m3, p5 = m5, p7 = m7;
      vld = 1'b0;
      din = 8'hEE;
      @(negedge clk);
      check({tag, " idle valid N=3"}, int'(v3), 0);
      check({tag, " idle valid N=5"}, int'(v5), 0);
      check({tag, " idle valid N=7"}, int'(v7), 0);
      check({tag, " idle hold N=3"}, int'(m3), int'(p3));
      check({tag, " idle hold N=5"}, int'(m5), int'(p5));
      check({tag, " idle hold N=7"}, int'(m7), int'(p7));
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1;
      vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      sent = 0;
      check({tag, " valid N=3"}, int'(v3), 0);
      check({tag, " valid N=5"}, int'(v5), 0);
      check({tag, " valid N=7"}, int'(v7), 0);
      check({tag, " median N=5"}, int'(m5), 0);
      check({tag, " median N=7"}, int'(m7), 0);
   endtask

   task automatic t_fill();
      for (int k = 0; k < 8; k++) push(8'(30 + 17 * k), "R2 fill");
   endtask

   task automatic t_random();
      for (int k = 0; k < 60; k++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         push(seed[23:16], "R3 random");
      end
      push(8'hFF, "R3 top");
      push(8'h00, "R3 zero");
      push(8'hFF, "R3 top");
      push(8'h80, "R3 mid");
   endtask

   task automatic t_constant();
      for (int k = 0; k < 10; k++) push(8'h5A, "R5 constant");
   endtask

   task automatic t_ties();
      logic [7:0] pat [10] = '{8'd3, 8'd3, 8'd7, 8'd3, 8'd7, 8'd7, 8'd1, 8'd3, 8'd7, 8'd1};
      for (int r = 0; r < 3; r++)
         for (int k = 0; k < 10; k++) push(pat[k], "R5 ties");
   endtask

   task automatic t_ramps();
      for (int k = 0; k < 20; k++) push(8'(12 * k), "R6 ramp up");
      for (int k = 20; k > 0; k--) push(8'(12 * k - 5), "R6 ramp down");
      for (int k = 0; k < 12; k++) push((k % 2 == 0) ? 8'(k) : 8'(250 - k), "R6 zigzag");
   endtask

   task automatic t_gaps();
      for (int k = 0; k < 8; k++) begin
         push(8'(200 - 23 * k), "R4 gap stream");
         idle("R4");
         if (k % 3 == 0) idle("R4");
      end
   endtask

   task automatic t_midreset();
      for (int k = 0; k < 4; k++) push(8'(90 + k), "R7 before reset");
      do_reset("R7 mid reset");
      for (int k = 0; k < 9; k++) push(8'(5 * k + 1), "R7 refill");
   endtask

   initial begin
      #(8ns * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int k = 0; k < 7; k++) hist[k] = '0;
      @(negedge clk);
      do_reset("R1 reset");
      t_fill();
      t_random();
      t_constant();
      t_ties();
      t_ramps();
      t_gaps();
      t_midreset();
      t_random();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule